// File: doc/BRIEF.md
# ADC Conversion Sweep Sequencer

This block is the digital front end of a 10-bit successive-approximation converter that has twelve multiplexed analog inputs. It waits, with the converter usually powered down, for a trigger from one of three selectable sources. It then powers the converter up, waits out a programmable settling delay and walks the channel slots in order. Each slot names a channel, either by slot number or through a user-programmed map. For every enabled channel the block holds the mux select for a programmable tracking interval, pulses start, waits for the converter's done strobe and captures the data.

Every captured result lands in two places: a shared register that also records which channel produced it, and a register owned by that channel. Each has a ready flag that a read strobe clears and an overrun flag that records a lost result. The same result is tested against a low and a high threshold in one of four window modes, and a match sets a sticky flag. At the end of a sweep the converter is powered down again if sleep is enabled.

Top module: `adc_sweep_ctrl`

## Requirements
- R1: Only channels whose bit in cfgChanEn is 1 are converted. With cfgUseSeq=0 the slots are visited in ascending channel order 0 to 11, so channel k is converted before channel k+1.
- R2: cfgTrigSel picks the sweep trigger. 0 is a high level on swTrig sampled at a clock edge. 1 is a rising edge on extTrigPin, taken after a two-flop synchronizer. 2 is a rising edge on timerTrig. 3 disables all triggers. The sources that are not selected have no effect, and a pin held high does not start another sweep.
- R3: With cfgLowRes=1 the result is the upper 8 bits of adcData, zero-extended, so lastData[9:8] is 0. With cfgLowRes=0 all 10 bits are kept.
- R4: Each result is written to lastData and to the register of its channel, and the channel number goes to lastCh. dataReady is set by the write and cleared by lastRead. chReady[k] is set by a write to channel k and cleared by chRdStb with chRdSel=k. chRdData shows the register selected by chRdSel.
- R5: cfgCmpMode selects the window test on the stored result: 0 is result < cfgLowThr, 1 is result > cfgHighThr, 2 is cfgLowThr <= result <= cfgHighThr, 3 is outside that range. A match sets cmpFlag, which stays set until cmpClr. A match in the same cycle as cmpClr wins.
- R6: With cfgSleep=1, adcPowerUp drops when a sweep ends. With cfgSleep=0 it stays high. adcPowerUp is low after reset. sweepDone pulses for one cycle after each sweep.
- R7: With cfgUseSeq=1, slot s converts the channel held in cfgSeq[4s+3:4s], for s from 0 to 11. Slots that name a disabled channel, or a value above 11, are skipped. A channel may appear in more than one slot.
- R8: When a sweep starts with the converter powered down and slot 0 enabled, busy is high for cfgStartup+cfgTrack+2 cycles before the first adcStart. When it is already powered, busy is high for cfgTrack+1 cycles.
- R9: A write to a channel register whose ready flag is still set sets chOvr for that channel. A write to the shared register while dataReady is set sets lastOvr. The matching read strobe clears the overrun flag. If the read and the write fall in the same cycle, ready stays set and no overrun is recorded.
- R10: A trigger that arrives while a sweep is running is ignored and does not queue another sweep.
- R11: adcStart is high for exactly one cycle per conversion. adcChSel holds from start until done, and the data is captured in the cycle adcDone is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgChanEn | input | 12 | Per-channel enable |
| cfgTrigSel | input | 2 | Trigger source select |
| cfgLowRes | input | 1 | 1 selects 8-bit results |
| cfgSleep | input | 1 | 1 powers down after each sweep |
| cfgUseSeq | input | 1 | 1 uses the programmed slot map |
| cfgSeq | input | 48 | Slot map, 4 bits per slot |
| cfgStartup | input | 8 | Wakeup settling delay in cycles |
| cfgTrack | input | 8 | Tracking interval in cycles |
| cfgCmpMode | input | 2 | Window comparison mode |
| cfgLowThr | input | 10 | Low threshold |
| cfgHighThr | input | 10 | High threshold |
| swTrig | input | 1 | Software trigger |
| extTrigPin | input | 1 | Asynchronous external trigger |
| timerTrig | input | 1 | Timer output trigger |
| adcStart | output | 1 | Conversion start pulse |
| adcChSel | output | 4 | Mux channel select |
| adcPowerUp | output | 1 | Converter power enable |
| adcDone | input | 1 | Conversion complete strobe |
| adcData | input | 10 | Converted value |
| lastData | output | 10 | Shared last result |
| lastCh | output | 4 | Channel of the last result |
| dataReady | output | 1 | Shared result unread |
| lastOvr | output | 1 | Shared result overrun |
| lastRead | input | 1 | Read strobe for the shared result |
| chRdSel | input | 4 | Channel register read select |
| chRdStb | input | 1 | Read strobe for the selected channel |
| chRdData | output | 10 | Selected channel result |
| chReady | output | 12 | Per-channel unread flags |
| chOvr | output | 12 | Per-channel overrun flags |
| cmpFlag | output | 1 | Sticky window match flag |
| cmpClr | input | 1 | Clears cmpFlag |
| busy | output | 1 | Sweep in progress |
| sweepDone | output | 1 | One-cycle end-of-sweep pulse |

## Verification
A result write and a consumer read strobe can land in the same clock, on both the shared and the per-channel registers. The converter model in the bench provokes this on demand: it raises lastRead and chRdStb in exactly the cycle it raises adcDone. The collision is judged correct if the flags left behind show a fresh unread result with no overrun, while the same sweep without the read does record an overrun. A window match landing on a flag clear is the second coincidence covered, and it is resolved in favour of the match.

// File: rtl/adc_sweep_pkg.sv
package adc_sweep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_SCAN,
    ST_TRACK,
    ST_CONV,
    ST_END
  } seqState_t;

  // trigger source codes
  localparam logic [1:0] TRG_SOFT  = 2'd0;
  localparam logic [1:0] TRG_PIN   = 2'd1;
  localparam logic [1:0] TRG_TIMER = 2'd2;

  // window comparison codes
  localparam logic [1:0] CMP_BELOW   = 2'd0;
  localparam logic [1:0] CMP_ABOVE   = 2'd1;
  localparam logic [1:0] CMP_INSIDE  = 2'd2;
  localparam logic [1:0] CMP_OUTSIDE = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic store;
    logic sweepEnd;
  } seqStrobe_t;

endpackage

// File: rtl/adc_sweep_ctl.sv
module adc_sweep_ctl
  import adc_sweep_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int CH_W   = 4,
  parameter int TIME_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [1:0]             trigSel,
  input  logic                   swTrig,
  input  logic                   extTrigPin,
  input  logic                   timerTrig,
  input  logic [NUM_CH-1:0]      chanEn,
  input  logic                   useSeq,
  input  logic [NUM_CH*CH_W-1:0] seqMap,
  input  logic                   sleepEn,
  input  logic [TIME_W-1:0]      startupCycles,
  input  logic [TIME_W-1:0]      trackCycles,
  input  logic                   adcDone,
  output logic                   adcStart,
  output logic [CH_W-1:0]        adcChSel,
  output logic                   adcPowerUp,
  output logic                   busy,
  output seqStrobe_t             strb,
  output logic [CH_W-1:0]        strbCh
);

  localparam logic [CH_W-1:0] LAST_SLOT = CH_W'(NUM_CH - 1);

  seqState_t         state;
  logic [CH_W-1:0]   slot;
  logic [CH_W-1:0]   curCh;
  logic [TIME_W-1:0] cnt;
  logic              awake;

  // trigger front end
  logic [1:0] pinSync;
  logic       pinLast;
  logic       timerLast;
  logic       pinRise;
  logic       timerRise;
  logic       trigHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinSync   <= '0;
      pinLast   <= 1'b0;
      timerLast <= 1'b0;
    end else begin
      pinSync   <= {pinSync[0], extTrigPin};
      pinLast   <= pinSync[1];
      timerLast <= timerTrig;
    end
  end

  assign pinRise   = pinSync[1] & ~pinLast;
  assign timerRise = timerTrig & ~timerLast;

  always_comb begin
    case (trigSel)
      TRG_SOFT:  trigHit = swTrig;
      TRG_PIN:   trigHit = pinRise;
      TRG_TIMER: trigHit = timerRise;
      default:   trigHit = 1'b0;
    endcase
  end

  // slot to channel mapping
  logic [CH_W-1:0] slotCh;
  logic            slotEn;
  logic            lastSlot;

  assign slotCh   = useSeq ? seqMap[slot*CH_W +: CH_W] : slot;
  assign lastSlot = (slot == LAST_SLOT);

  always_comb begin
    slotEn = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (slotCh == CH_W'(i)) slotEn = chanEn[i];
    end
  end

  // sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      slot  <= '0;
      curCh <= '0;
      cnt   <= '0;
      awake <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (trigHit) begin
            slot <= '0;
            if (!awake) begin
              awake <= 1'b1;
              cnt   <= startupCycles;
              state <= ST_WAKE;
            end else begin
              state <= ST_SCAN;
            end
          end
        end
        ST_WAKE: begin
          if (cnt == '0) state <= ST_SCAN;
          else           cnt   <= cnt - 1'b1;
        end
        ST_SCAN: begin
          if (slotEn) begin
            curCh <= slotCh;
            cnt   <= trackCycles;
            state <= ST_TRACK;
          end else if (lastSlot) begin
            state <= ST_END;
          end else begin
            slot <= slot + 1'b1;
          end
        end
        ST_TRACK: begin
          if (cnt == '0) state <= ST_CONV;
          else           cnt   <= cnt - 1'b1;
        end
        ST_CONV: begin
          if (adcDone) begin
            if (lastSlot) begin
              state <= ST_END;
            end else begin
              slot  <= slot + 1'b1;
              state <= ST_SCAN;
            end
          end
        end
        ST_END: begin
          if (sleepEn) awake <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign adcStart      = (state == ST_TRACK) && (cnt == '0);
  assign adcChSel      = curCh;
  assign adcPowerUp    = awake;
  assign busy          = (state != ST_IDLE);
  assign strb.store    = (state == ST_CONV) && adcDone;
  assign strb.sweepEnd = (state == ST_END);
  assign strbCh        = curCh;

  // R11
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  // R11
  chsel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adcStart || (state == ST_CONV && !adcDone)) |=> $stable(adcChSel));

  // R2
  sweep_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(trigHit));

  // R6
  sleep_after_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sweepEnd && sleepEn) |=> !adcPowerUp);

endmodule

// File: rtl/adc_sweep_dp.sv
module adc_sweep_dp
  import adc_sweep_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int CH_W   = 4,
  parameter int DATA_W = 10,
  parameter int LOW_W  = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobe_t             strb,
  input  logic [CH_W-1:0]        strbCh,
  input  logic [DATA_W-1:0]      adcData,
  input  logic                   lowRes,
  input  logic [1:0]             cmpMode,
  input  logic [DATA_W-1:0]      lowThr,
  input  logic [DATA_W-1:0]      highThr,
  input  logic                   lastRead,
  input  logic                   cmpClr,
  input  logic [CH_W-1:0]        chRdSel,
  input  logic                   chRdStb,
  output logic [DATA_W-1:0]      lastData,
  output logic [CH_W-1:0]        lastCh,
  output logic                   dataReady,
  output logic                   lastOvr,
  output logic [DATA_W-1:0]      chRdData,
  output logic [NUM_CH-1:0]      chReady,
  output logic [NUM_CH-1:0]      chOvr,
  output logic                   cmpFlag,
  output logic                   sweepDone
);

  localparam int DROP = DATA_W - LOW_W;

  logic [DATA_W-1:0] res;
  logic              hit;

  assign res = lowRes ? DATA_W'(adcData >> DROP) : adcData;

  always_comb begin
    case (cmpMode)
      CMP_BELOW:  hit = (res < lowThr);
      CMP_ABOVE:  hit = (res > highThr);
      CMP_INSIDE: hit = (res >= lowThr) && (res <= highThr);
      default:    hit = (res < lowThr) || (res > highThr);
    endcase
  end

  // per-channel write and read decode
  logic [NUM_CH-1:0] wrVec;
  logic [NUM_CH-1:0] rdVec;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      wrVec[i] = strb.store && (strbCh == CH_W'(i));
      rdVec[i] = chRdStb && (chRdSel == CH_W'(i));
    end
  end

  logic [NUM_CH-1:0][DATA_W-1:0] chData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chData  <= '0;
      chReady <= '0;
      chOvr   <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (wrVec[i]) chData[i] <= res;
        chReady[i] <= wrVec[i] | (chReady[i] & ~rdVec[i]);
        chOvr[i]   <= ~rdVec[i] & (chOvr[i] | (wrVec[i] & chReady[i]));
      end
    end
  end

  always_comb begin
    chRdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chRdSel == CH_W'(i)) chRdData = chData[i];
    end
  end

  // shared result, flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastData  <= '0;
      lastCh    <= '0;
      dataReady <= 1'b0;
      lastOvr   <= 1'b0;
      cmpFlag   <= 1'b0;
      sweepDone <= 1'b0;
    end else begin
      if (strb.store) begin
        lastData <= res;
        lastCh   <= strbCh;
      end
      dataReady <= strb.store | (dataReady & ~lastRead);
      lastOvr   <= ~lastRead & (lastOvr | (strb.store & dataReady));
      cmpFlag   <= (strb.store & hit) | (cmpFlag & ~cmpClr);
      sweepDone <= strb.sweepEnd;
    end
  end

  // R4
  ready_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.store |=> (dataReady && lastCh == $past(strbCh)));

  // R9
  shared_ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.store && dataReady && !lastRead) |=> lastOvr);

  // R3
  low_res_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.store && lowRes) |=> (lastData[DATA_W-1:LOW_W] == '0));

  // R5
  cmp_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpClr && !strb.store) |=> !cmpFlag);

endmodule

// File: rtl/adc_sweep_ctrl.sv
module adc_sweep_ctrl
  import adc_sweep_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int DATA_W = 10,
  parameter int LOW_W  = 8,
  parameter int TIME_W = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CH-1:0]      cfgChanEn,
  input  logic [1:0]             cfgTrigSel,
  input  logic                   cfgLowRes,
  input  logic                   cfgSleep,
  input  logic                   cfgUseSeq,
  input  logic [NUM_CH*CH_W-1:0] cfgSeq,
  input  logic [TIME_W-1:0]      cfgStartup,
  input  logic [TIME_W-1:0]      cfgTrack,
  input  logic [1:0]             cfgCmpMode,
  input  logic [DATA_W-1:0]      cfgLowThr,
  input  logic [DATA_W-1:0]      cfgHighThr,
  input  logic                   swTrig,
  input  logic                   extTrigPin,
  input  logic                   timerTrig,
  output logic                   adcStart,
  output logic [CH_W-1:0]        adcChSel,
  output logic                   adcPowerUp,
  input  logic                   adcDone,
  input  logic [DATA_W-1:0]      adcData,
  output logic [DATA_W-1:0]      lastData,
  output logic [CH_W-1:0]        lastCh,
  output logic                   dataReady,
  output logic                   lastOvr,
  input  logic                   lastRead,
  input  logic [CH_W-1:0]        chRdSel,
  input  logic                   chRdStb,
  output logic [DATA_W-1:0]      chRdData,
  output logic [NUM_CH-1:0]      chReady,
  output logic [NUM_CH-1:0]      chOvr,
  output logic                   cmpFlag,
  input  logic                   cmpClr,
  output logic                   busy,
  output logic                   sweepDone
);

  seqStrobe_t      strb;
  logic [CH_W-1:0] strbCh;

  adc_sweep_ctl #(
    .NUM_CH(NUM_CH),
    .CH_W  (CH_W),
    .TIME_W(TIME_W)
  ) u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .trigSel      (cfgTrigSel),
    .swTrig       (swTrig),
    .extTrigPin   (extTrigPin),
    .timerTrig    (timerTrig),
    .chanEn       (cfgChanEn),
    .useSeq       (cfgUseSeq),
    .seqMap       (cfgSeq),
    .sleepEn      (cfgSleep),
    .startupCycles(cfgStartup),
    .trackCycles  (cfgTrack),
    .adcDone      (adcDone),
    .adcStart     (adcStart),
    .adcChSel     (adcChSel),
    .adcPowerUp   (adcPowerUp),
    .busy         (busy),
    .strb         (strb),
    .strbCh       (strbCh)
  );

  adc_sweep_dp #(
    .NUM_CH(NUM_CH),
    .CH_W  (CH_W),
    .DATA_W(DATA_W),
    .LOW_W (LOW_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .strbCh   (strbCh),
    .adcData  (adcData),
    .lowRes   (cfgLowRes),
    .cmpMode  (cfgCmpMode),
    .lowThr   (cfgLowThr),
    .highThr  (cfgHighThr),
    .lastRead (lastRead),
    .cmpClr   (cmpClr),
    .chRdSel  (chRdSel),
    .chRdStb  (chRdStb),
    .lastData (lastData),
    .lastCh   (lastCh),
    .dataReady(dataReady),
    .lastOvr  (lastOvr),
    .chRdData (chRdData),
    .chReady  (chReady),
    .chOvr    (chOvr),
    .cmpFlag  (cmpFlag),
    .sweepDone(sweepDone)
  );

  // R1
  enabled_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.store |-> cfgChanEn[strbCh]);

endmodule

// File: tb/sim_adc_sweep_ctrl.sv
`timescale 1ns/1ps
module sim_adc_sweep_ctrl;

  localparam int NCH = 12;
  localparam int DW  = 10;
  localparam int CW  = 4;
  localparam int TW  = 8;

  typedef struct packed {
    logic [1:0]    mode;
    logic [DW-1:0] lo;
    logic [DW-1:0] hi;
    logic [DW-1:0] raw;
    logic          lowRes;
    logic          hit;
  } vec_t;

  localparam vec_t VEC [0:9] = '{
    '{2'd0, 10'd100, 10'd500, 10'd99,   1'b0, 1'b1},
    '{2'd0, 10'd100, 10'd500, 10'd100,  1'b0, 1'b0},
    '{2'd1, 10'd100, 10'd500, 10'd501,  1'b0, 1'b1},
    '{2'd1, 10'd100, 10'd500, 10'd500,  1'b0, 1'b0},
    '{2'd2, 10'd100, 10'd500, 10'd100,  1'b0, 1'b1},
    '{2'd2, 10'd100, 10'd500, 10'd501,  1'b0, 1'b0},
    '{2'd3, 10'd100, 10'd500, 10'd50,   1'b0, 1'b1},
    '{2'd3, 10'd100, 10'd500, 10'd300,  1'b0, 1'b0},
    '{2'd1, 10'd0,   10'd200, 10'd1023, 1'b1, 1'b1},
    '{2'd0, 10'd100, 10'd500, 10'd400,  1'b1, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic [NCH-1:0]    cfgChanEn;
  logic [1:0]        cfgTrigSel;
  logic              cfgLowRes, cfgSleep, cfgUseSeq;
  logic [NCH*CW-1:0] cfgSeq;
  logic [TW-1:0]     cfgStartup, cfgTrack;
  logic [1:0]        cfgCmpMode;
  logic [DW-1:0]     cfgLowThr, cfgHighThr;
  logic              swTrig, extTrigPin, timerTrig;
  logic              adcStart, adcPowerUp, adcDone;
  logic [CW-1:0]     adcChSel;
  logic [DW-1:0]     adcData;
  logic [DW-1:0]     lastData;
  logic [CW-1:0]     lastCh;
  logic              dataReady, lastOvr;
  logic [CW-1:0]     chRdSel;
  logic [DW-1:0]     chRdData;
  logic [NCH-1:0]    chReady, chOvr;
  logic              cmpFlag, cmpClr, busy, sweepDone;

  logic tbLastRd, tbChRd, modelLastRd, modelChRd, collideArm;
  logic lastRead, chRdStb;
  assign lastRead = tbLastRd | modelLastRd;
  assign chRdStb  = tbChRd | modelChRd;

  always #2.5 clk = ~clk;

  adc_sweep_ctrl u0 (
    .clk(clk), .rstN(rstN), .cfgChanEn(cfgChanEn), .cfgTrigSel(cfgTrigSel),
    .cfgLowRes(cfgLowRes), .cfgSleep(cfgSleep), .cfgUseSeq(cfgUseSeq),
    .cfgSeq(cfgSeq), .cfgStartup(cfgStartup), .cfgTrack(cfgTrack),
    .cfgCmpMode(cfgCmpMode), .cfgLowThr(cfgLowThr), .cfgHighThr(cfgHighThr),
    .swTrig(swTrig), .extTrigPin(extTrigPin), .timerTrig(timerTrig),
    .adcStart(adcStart), .adcChSel(adcChSel), .adcPowerUp(adcPowerUp),
    .adcDone(adcDone), .adcData(adcData), .lastData(lastData), .lastCh(lastCh),
    .dataReady(dataReady), .lastOvr(lastOvr), .lastRead(lastRead),
    .chRdSel(chRdSel), .chRdStb(chRdStb), .chRdData(chRdData),
    .chReady(chReady), .chOvr(chOvr), .cmpFlag(cmpFlag), .cmpClr(cmpClr),
    .busy(busy), .sweepDone(sweepDone)
  );

  // converter model: done three falling edges after start is seen
  logic [DW-1:0] modelVal [NCH];
  int modelCnt = 0;
  always @(negedge clk) begin
    adcDone     = 1'b0;
    modelLastRd = 1'b0;
    modelChRd   = 1'b0;
    if (modelCnt > 0) begin
      modelCnt = modelCnt - 1;
      if (modelCnt == 0) begin
        adcDone = 1'b1;
        adcData = modelVal[adcChSel];
        if (collideArm) begin
          modelLastRd = 1'b1;
          modelChRd   = 1'b1;
        end
      end
    end
    if (adcStart) modelCnt = 3;
  end

  // start monitor
  int       nStart = 0;
  int       monBad = 0;
  logic     prevStart = 1'b0;
  logic [CW-1:0] startLog [64];
  always @(negedge clk) begin
    if (adcStart) begin
      if (nStart < 64) startLog[nStart] = adcChSel;
      nStart = nStart + 1;
    end
    if (adcStart && prevStart) monBad = monBad + 1;
    prevStart = adcStart;
  end

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseSoft();
    @(negedge clk); swTrig = 1'b1;
    @(negedge clk); swTrig = 1'b0;
  endtask

  task automatic waitDone();
    bit seen = 1'b0;
    for (int n = 0; n < 5000 && !seen; n++) begin
      @(negedge clk);
      if (sweepDone) seen = 1'b1;
    end
    if (!seen) check(1'b0, "sweep timeout", 0, 1);
  endtask

  task automatic runSoft();
    pulseSoft();
    waitDone();
  endtask

  task automatic clearAll();
    @(negedge clk); tbLastRd = 1'b1; cmpClr = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      chRdSel = CW'(c); tbChRd = 1'b1;
      @(negedge clk);
      tbLastRd = 1'b0; cmpClr = 1'b0;
    end
    tbChRd = 1'b0;
  endtask

  task automatic measure(output int pre);
    bit got = 1'b0;
    pre = 0;
    @(negedge clk); swTrig = 1'b1;
    for (int n = 0; n < 2000 && !got; n++) begin
      @(negedge clk);
      swTrig = 1'b0;
      if (adcStart) got = 1'b1;
      else if (busy) pre = pre + 1;
    end
    waitDone();
  endtask

  initial begin
    int n0, pre;
    logic [DW-1:0] expD;
    rstN = 1'b0; cfgChanEn = '0; cfgTrigSel = 2'd0; cfgLowRes = 1'b0;
    cfgSleep = 1'b0; cfgUseSeq = 1'b0; cfgSeq = '0; cfgStartup = 8'd3;
    cfgTrack = 8'd2; cfgCmpMode = 2'd0; cfgLowThr = '0; cfgHighThr = '0;
    swTrig = 1'b0; extTrigPin = 1'b0; timerTrig = 1'b0; adcDone = 1'b0;
    adcData = '0; tbLastRd = 1'b0; tbChRd = 1'b0; chRdSel = '0; cmpClr = 1'b0;
    modelLastRd = 1'b0; modelChRd = 1'b0; collideArm = 1'b0;
    for (int c = 0; c < NCH; c++) modelVal[c] = DW'(37 * c + 11);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state (R4, R6, R9)
    check(!dataReady && !lastOvr, "R4 reset ready/ovr", int'(dataReady), 0);
    check(chReady == '0 && chOvr == '0, "R9 reset channel flags", int'(chReady), 0);
    check(!adcPowerUp && !busy && !adcStart, "R6 reset power/busy", int'(adcPowerUp), 0);
    check(!cmpFlag, "R5 reset cmpFlag", int'(cmpFlag), 0);

    // window compare and resolution table (R5, R3)
    cfgChanEn = 12'b1 << 5;
    for (int v = 0; v < 10; v++) begin
      cfgCmpMode = VEC[v].mode; cfgLowThr = VEC[v].lo; cfgHighThr = VEC[v].hi;
      cfgLowRes = VEC[v].lowRes; modelVal[5] = VEC[v].raw;
      runSoft();
      expD = VEC[v].lowRes ? (VEC[v].raw >> 2) : VEC[v].raw;
      check(lastData == expD, "R3 stored value", int'(lastData), int'(expD));
      check(cmpFlag == VEC[v].hit, "R5 window match", int'(cmpFlag), int'(VEC[v].hit));
      chRdSel = 4'd5; #1;
      check(chRdData == expD && lastCh == 4'd5, "R4 channel copy", int'(chRdData), int'(expD));
      @(negedge clk); cmpClr = 1'b1; tbLastRd = 1'b1; tbChRd = 1'b1;
      @(negedge clk); cmpClr = 1'b0; tbLastRd = 1'b0; tbChRd = 1'b0;
    end
    check(!cmpFlag && !dataReady && !chReady[5], "R5 clear strobes", int'(cmpFlag), 0);
    cfgLowRes = 1'b0; cfgCmpMode = 2'd0; cfgLowThr = '0; modelVal[5] = DW'(37 * 5 + 11);

    // ascending order over enabled channels (R1)
    cfgChanEn = (12'b1 << 1) | (12'b1 << 4) | (12'b1 << 11);
    n0 = nStart;
    runSoft();
    check(nStart - n0 == 3, "R1 conversion count", nStart - n0, 3);
    check(startLog[n0] == 4'd1 && startLog[n0+1] == 4'd4 && startLog[n0+2] == 4'd11,
          "R1 order", int'(startLog[n0+1]), 4);
    chRdSel = 4'd4; #1;
    check(chRdData == modelVal[4], "R4 ch4 register", int'(chRdData), int'(modelVal[4]));
    check(lastCh == 4'd11 && lastData == modelVal[11], "R4 last channel", int'(lastCh), 11);
    check(chReady == cfgChanEn, "R4 ready per channel", int'(chReady), int'(cfgChanEn));
    clearAll();

    // programmed sequence with duplicate slot (R7, R9)
    cfgChanEn = (12'b1 << 2) | (12'b1 << 7) | (12'b1 << 9);
    cfgSeq = '0;
    cfgSeq[0*CW +: CW] = 4'd7;
    cfgSeq[1*CW +: CW] = 4'd2;
    cfgSeq[2*CW +: CW] = 4'd9;
    cfgSeq[5*CW +: CW] = 4'd2;
    cfgSeq[8*CW +: CW] = 4'd15;
    cfgUseSeq = 1'b1;
    n0 = nStart;
    runSoft();
    check(nStart - n0 == 4, "R7 sequence count", nStart - n0, 4);
    check(startLog[n0] == 4'd7 && startLog[n0+1] == 4'd2 && startLog[n0+2] == 4'd9 &&
          startLog[n0+3] == 4'd2, "R7 sequence order", int'(startLog[n0]), 7);
    check(chOvr[2] && !chOvr[7], "R9 repeated channel overrun", int'(chOvr), 4);
    cfgUseSeq = 1'b0;
    clearAll();

    // overrun and same-cycle read collision (R9, R4)
    cfgChanEn = 12'b1 << 3;
    runSoft();
    runSoft();
    check(lastOvr && chOvr[3] && dataReady, "R9 overrun set", int'(lastOvr), 1);
    chRdSel = 4'd3;
    @(negedge clk); tbLastRd = 1'b1; tbChRd = 1'b1;
    @(negedge clk); tbLastRd = 1'b0; tbChRd = 1'b0;
    check(!lastOvr && !chOvr[3] && !dataReady && !chReady[3], "R9 read clears", int'(chReady[3]), 0);
    runSoft();
    collideArm = 1'b1;
    runSoft();
    collideArm = 1'b0;
    check(dataReady && !lastOvr, "R9 shared collision", int'(lastOvr), 0);
    check(chReady[3] && !chOvr[3], "R9 channel collision", int'(chOvr[3]), 0);
    clearAll();

    // trigger during sweep (R10)
    cfgChanEn = (12'b1 << 0) | (12'b1 << 6) | (12'b1 << 10);
    n0 = nStart;
    pulseSoft();
    repeat (6) @(negedge clk);
    check(busy, "R10 sweep running", int'(busy), 1);
    swTrig = 1'b1; @(negedge clk); swTrig = 1'b0;
    waitDone();
    repeat (30) @(negedge clk);
    check(nStart - n0 == 3 && !busy, "R10 extra trigger ignored", nStart - n0, 3);
    clearAll();

    // trigger sources (R2)
    cfgTrigSel = 2'd1;
    n0 = nStart;
    pulseSoft();
    repeat (30) @(negedge clk);
    check(nStart == n0 && !busy, "R2 soft ignored in pin mode", nStart - n0, 0);
    extTrigPin = 1'b1;
    waitDone();
    repeat (30) @(negedge clk);
    check(nStart - n0 == 3, "R2 pin edge single sweep", nStart - n0, 3);
    extTrigPin = 1'b0;
    cfgTrigSel = 2'd2;
    repeat (5) @(negedge clk);
    n0 = nStart;
    extTrigPin = 1'b1;
    repeat (30) @(negedge clk);
    check(nStart == n0, "R2 pin ignored in timer mode", nStart - n0, 0);
    extTrigPin = 1'b0;
    timerTrig = 1'b1;
    waitDone();
    timerTrig = 1'b0;
    check(nStart - n0 == 3, "R2 timer edge sweep", nStart - n0, 3);
    cfgTrigSel = 2'd3;
    n0 = nStart;
    pulseSoft();
    timerTrig = 1'b1;
    repeat (30) @(negedge clk);
    timerTrig = 1'b0;
    check(nStart == n0 && !busy, "R2 disabled triggers", nStart - n0, 0);
    cfgTrigSel = 2'd0;
    clearAll();

    // startup, tracking and sleep (R6, R8)
    cfgChanEn = 12'b1;
    cfgSleep = 1'b1; cfgStartup = 8'd5; cfgTrack = 8'd3;
    measure(pre);
    check(pre == 4, "R8 awake lead time", pre, 4);
    check(!adcPowerUp, "R6 sleep after sweep", int'(adcPowerUp), 0);
    measure(pre);
    check(pre == 10, "R8 wake lead time", pre, 10);
    cfgSleep = 1'b0; cfgTrack = 8'd1;
    measure(pre);
    check(pre == 8, "R8 wake lead time short track", pre, 8);
    check(adcPowerUp, "R6 stays powered", int'(adcPowerUp), 1);
    measure(pre);
    check(pre == 2, "R8 awake short track", pre, 2);

    // start pulse shape (R11)
    check(monBad == 0, "R11 start width", monBad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule